// File: doc/BRIEF.md
# Bordered Raster Timing Generator

This block sequences a display raster for a video DAC. A pixel counter runs along each line and a line counter runs down each frame. Every line and every frame passes through six regions in a fixed order: sync pulse, back porch, leading border, visible area, trailing border and front porch. The block decodes the current position into horizontal and vertical sync, a visible-area flag, a border flag and the raw pixel and line positions.

Software programs the block with plain register write strobes. Three timing words per axis each carry two 12-bit region edges. A control word starts and stops the raster and picks each sync polarity. A reset word holds the block in a soft reset. Timing writes land in pending copies and are applied only at a frame boundary, so no frame mixes two configurations. Control writes act at once.

Top module: `raster_tgen`

## Requirements
- R1: Each timing word (addresses 0–2 horizontal, 3–5 vertical) carries one field in bits 11:0 and another in bits 27:16. Bits 15:12 and 31:28 have no effect. Address 0/3 holds the period (low) and the sync end (high). Address 1/4 holds the leading-border start (low) and the visible start (high). Address 2/5 holds the trailing-border start (low) and the front-porch start (high).
- R2: While running, the pixel position counts 0 to period−1 and returns to 0. The line position advances only when the pixel position wraps, and it returns to 0 after its own period−1. Both positions appear on the coordinate outputs.
- R3: A sync output is asserted while its axis position is below that axis's sync end.
- R4: Control bit 1 sets the horizontal sync polarity and control bit 3 sets the vertical one. A 1 drives sync high when asserted; a 0 drives sync low when asserted. The idle level is the inverse.
- R5: The visible flag is high only when both positions lie at or above the visible start and below the trailing-border start.
- R6: The border flag is high when both positions lie at or above the leading-border start and below the front-porch start, and the visible flag is low.
- R7: The raster runs only when control bit 31 is 1 and bits 0 and 2 are both 0. Otherwise both coordinates read 0, both syncs sit at their idle level and both flags are low. The first running cycle shows position (0,0).
- R8: A timing write made while running takes effect at the next return to position (0,0). The rest of the current frame uses the old values. While stopped, a timing write applies from the next cycle.
- R9: Writing 0 to bit 8 of the reset word (address 7) holds the block in soft reset. The control word clears, and writes to every other address are ignored. Writing 1 to bit 8 releases the block with the control word still clear.
- R10: After the hard reset input, the block is released from soft reset, stopped, with both polarities negative and all timing fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous-free active-low hard reset, sampled on the clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0–5 timing, 6 control, 7 reset word) |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync at the programmed polarity |
| vsync_o | output | 1 | Vertical sync at the programmed polarity |
| active_o | output | 1 | Visible area flag |
| border_o | output | 1 | Border flag (inside border rectangle, outside visible area) |
| h_pos_o | output | 12 | Current pixel position within the line |
| v_pos_o | output | 12 | Current line position within the frame |

## Verification
Every output is decoded from the position registers without further delay. A write sampled at clock edge k is visible right after edge k. A run command shows position (0,0) after edge k and position n after edge k+n. A timing write made mid-frame becomes visible only in the cycle after the edge on which the frame wraps. The bench models the register file and counters one edge at a time. It stamps each expected output set with the cycle number at which it is due, and a monitor compares the outputs on the falling edge of exactly that cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // width of one programmable region edge
    localparam int RTG_FW     = 12;
    // width of the register data bus and address
    localparam int RTG_DW     = 32;
    localparam int RTG_AW     = 3;
    // lsb of the upper packed field in a timing word
    localparam int RTG_HI_LSB = 16;

    // control word bit positions
    localparam int CB_VSTOP = 0;
    localparam int CB_HPOL  = 1;
    localparam int CB_HSTOP = 2;
    localparam int CB_VPOL  = 3;
    localparam int CB_RUN   = 31;
    // release bit in the reset word
    localparam int RB_REL   = 8;

    typedef logic [RTG_FW-1:0] rtg_cnt_t;

    // region edges of one axis, in the order the regions are visited
    typedef struct packed {
        rtg_cnt_t total;
        rtg_cnt_t sync_end;
        rtg_cnt_t brd_lead;
        rtg_cnt_t disp_start;
        rtg_cnt_t brd_trail;
        rtg_cnt_t fporch;
    } rtg_axis_cfg_t;

    typedef enum logic [RTG_AW-1:0] {
        RA_H_TOT   = 3'd0,
        RA_H_LEAD  = 3'd1,
        RA_H_TRAIL = 3'd2,
        RA_V_TOT   = 3'd3,
        RA_V_LEAD  = 3'd4,
        RA_V_TRAIL = 3'd5,
        RA_CTRL    = 3'd6,
        RA_RST     = 3'd7
    } rtg_addr_e;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [RTG_AW-1:0]   wr_addr_i,
    input  logic [RTG_DW-1:0]   wr_data_i,
    output rtg_axis_cfg_t       pend_h_o,
    output rtg_axis_cfg_t       pend_v_o,
    output logic                run_o,
    output logic                hpol_o,
    output logic                vpol_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_SLOT = 3;

    typedef struct packed {
        logic          rel;
        logic          run;
        logic          hstop;
        logic          vstop;
        logic          hpol;
        logic          vpol;
        rtg_axis_cfg_t ph;
        rtg_axis_cfg_t pv;
    } regs_t;

    regs_t     st_d, st_q;
    rtg_addr_e addr;

    assign addr = rtg_addr_e'(wr_addr_i);

    // place the two packed fields of a timing word into the pending set
    function automatic rtg_axis_cfg_t put_pair(rtg_axis_cfg_t c, int slot,
                                               logic [RTG_DW-1:0] w);
        rtg_axis_cfg_t r;
        rtg_cnt_t      lo;
        rtg_cnt_t      hi;
        r  = c;
        lo = w[RTG_FW-1:0];
        hi = w[RTG_HI_LSB +: RTG_FW];
        case (slot)
            0:       begin r.total     = lo; r.sync_end   = hi; end
            1:       begin r.brd_lead  = lo; r.disp_start = hi; end
            default: begin r.brd_trail = lo; r.fporch     = hi; end
        endcase
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (!st_q.rel) begin
            st_d.run   = 1'b0;
            st_d.hstop = 1'b0;
            st_d.vstop = 1'b0;
            st_d.hpol  = 1'b0;
            st_d.vpol  = 1'b0;
        end
        if (wr_en_i) begin
            if (addr == RA_RST) begin
                st_d.rel = wr_data_i[RB_REL];
            end else if (st_q.rel) begin
                if (addr == RA_CTRL) begin
                    st_d.run   = wr_data_i[CB_RUN];
                    st_d.hstop = wr_data_i[CB_HSTOP];
                    st_d.vstop = wr_data_i[CB_VSTOP];
                    st_d.hpol  = wr_data_i[CB_HPOL];
                    st_d.vpol  = wr_data_i[CB_VPOL];
                end else if (int'(wr_addr_i) < N_SLOT) begin
                    st_d.ph = put_pair(st_q.ph, int'(wr_addr_i), wr_data_i);
                end else begin
                    st_d.pv = put_pair(st_q.pv, int'(wr_addr_i) - N_SLOT, wr_data_i);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.rel <= 1'b1;
        end else begin
            st_q     <= st_d;
        end
    end

    assign pend_h_o = st_q.ph;
    assign pend_v_o = st_q.pv;
    assign run_o    = st_q.rel & st_q.run & ~st_q.hstop & ~st_q.vstop;
    assign hpol_o   = st_q.hpol;
    assign vpol_o   = st_q.vpol;

    // R9: a held block comes out of the next edge with control cleared
    p_held_ctrl_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.rel |=> (!run_o && !hpol_o && !vpol_o));

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           clear_i,
    input  logic           adv_i,
    input  logic           load_i,
    input  rtg_axis_cfg_t  pend_i,
    output rtg_cnt_t       pos_o,
    output logic           last_o,
    output logic           sync_o,
    output logic           rect_o,
    output logic           disp_o,
    output rtg_axis_cfg_t  cfg_o
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        rtg_cnt_t      pos;
        rtg_axis_cfg_t cfg;
    } axis_t;

    axis_t ax_d, ax_q;

    always_comb begin
        ax_d = ax_q;
        if (clear_i) begin
            ax_d.pos = '0;
        end else if (adv_i) begin
            ax_d.pos = last_o ? '0 : ax_q.pos + rtg_cnt_t'(1);
        end
        if (load_i) begin
            ax_d.cfg = pend_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ax_q <= '0;
        end else begin
            ax_q <= ax_d;
        end
    end

    assign pos_o  = ax_q.pos;
    assign cfg_o  = ax_q.cfg;
    assign last_o = (ax_q.pos == ax_q.cfg.total - rtg_cnt_t'(1));
    assign sync_o = (ax_q.pos < ax_q.cfg.sync_end);
    assign rect_o = (ax_q.pos >= ax_q.cfg.brd_lead) && (ax_q.pos < ax_q.cfg.fporch);
    assign disp_o = (ax_q.pos >= ax_q.cfg.disp_start) && (ax_q.pos < ax_q.cfg.brd_trail);

    // R2: the position never leaves the programmed period
    p_pos_in_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ax_q.cfg.total != '0) |-> (ax_q.pos < ax_q.cfg.total));

endmodule

// File: rtl/raster_tgen.sv
module raster_tgen
    import rtg_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [RTG_AW-1:0]  wr_addr_i,
    input  logic [RTG_DW-1:0]  wr_data_i,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               active_o,
    output logic               border_o,
    output logic [RTG_FW-1:0]  h_pos_o,
    output logic [RTG_FW-1:0]  v_pos_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NAX  = 2;
    localparam int AX_H = 0;
    localparam int AX_V = 1;

    rtg_axis_cfg_t  pend [NAX];
    rtg_axis_cfg_t  live [NAX];
    rtg_cnt_t       pos  [NAX];
    logic [NAX-1:0] last, sync, rect, disp, adv;
    logic           run, hpol, vpol, frame_end, load, clear;

    rtg_regs i_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .pend_h_o  (pend[AX_H]),
        .pend_v_o  (pend[AX_V]),
        .run_o     (run),
        .hpol_o    (hpol),
        .vpol_o    (vpol)
    );

    // each axis advances only when every faster axis wraps
    always_comb begin
        adv[AX_H] = run;
        adv[AX_V] = run & last[AX_H];
    end

    assign frame_end = run & (&last);
    assign clear     = ~run;
    assign load      = ~run | frame_end;

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        rtg_axis i_axis (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (clear),
            .adv_i   (adv[a]),
            .load_i  (load),
            .pend_i  (pend[a]),
            .pos_o   (pos[a]),
            .last_o  (last[a]),
            .sync_o  (sync[a]),
            .rect_o  (rect[a]),
            .disp_o  (disp[a]),
            .cfg_o   (live[a])
        );
    end

    assign hsync_o  = (run & sync[AX_H]) ? hpol : ~hpol;
    assign vsync_o  = (run & sync[AX_V]) ? vpol : ~vpol;
    assign active_o = run & (&disp);
    assign border_o = run & (&rect) & ~(&disp);
    assign h_pos_o  = run ? pos[AX_H] : '0;
    assign v_pos_o  = run ? pos[AX_V] : '0;

    // R7: every start shows the frame origin
    p_start_at_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run) |-> (h_pos_o == '0 && v_pos_o == '0));

    // R2: the line position only moves together with a pixel wrap
    p_line_waits_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && $past(run) && h_pos_o != '0) |-> $stable(v_pos_o));

    // R8: the applied timing stays fixed away from the frame origin
    p_live_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && $past(run) && (h_pos_o != '0 || v_pos_o != '0))
            |-> ($stable(live[AX_H]) && $stable(live[AX_V])));

    // R3: a line with a sync pulse begins with sync asserted
    p_line_opens_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && h_pos_o == '0 && live[AX_H].sync_end != '0) |-> (hsync_o == hpol));

endmodule

// File: tb/test_raster_tgen.sv
module test_raster_tgen;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        hsync, vsync, active, border;
    logic [11:0] h_pos, v_pos;

    always #2 clk = ~clk;   // 4 ns period

    raster_tgen i_raster_tgen (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .hsync_o   (hsync),
        .vsync_o   (vsync),
        .active_o  (active),
        .border_o  (border),
        .h_pos_o   (h_pos),
        .v_pos_o   (v_pos)
    );

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    string phase = "R10";

    typedef struct {
        int          cyc;
        logic        hs, vs, act, bord;
        logic [11:0] x, y;
        string       ph;
    } exp_t;

    exp_t sb_q[$];

    // reference state built from the requirements
    logic [11:0] pend_h[6], pend_v[6], live_h[6], live_v[6];
    logic [11:0] mh, mv;
    logic [31:0] mctl;
    logic        mrel;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string ph, logic [31:0] got, logic [31:0] want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s (phase %s) cycle %0d: actual %0h expected %0h",
                     req, ph, cyc, got, want);
        end
    endtask

    function automatic logic m_run();
        return mrel && mctl[31] && !mctl[0] && !mctl[2];
    endfunction

    // one clock of stimulus; the expected outputs after that edge are queued
    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d);
        logic run_old, hl, vl, rn, hin, vin, hr, vr, hd, vd;
        exp_t e;
        wr_en = w; wr_addr = a; wr_data = d;
        run_old = m_run();
        hl = (mh == live_h[0] - 12'd1);
        vl = (mv == live_v[0] - 12'd1);
        if (!run_old) begin
            mh = '0; mv = '0;
            for (int i = 0; i < 6; i++) begin live_h[i] = pend_h[i]; live_v[i] = pend_v[i]; end
        end else if (hl) begin
            mh = '0;
            if (vl) begin
                mv = '0;
                for (int i = 0; i < 6; i++) begin live_h[i] = pend_h[i]; live_v[i] = pend_v[i]; end
            end else begin
                mv = mv + 12'd1;
            end
        end else begin
            mh = mh + 12'd1;
        end
        if (!mrel) mctl = '0;
        if (w) begin
            if (a == 3'd7) mrel = d[8];
            else if (mrel) begin
                if (a == 3'd6) mctl = d;
                else if (a < 3'd3) begin
                    pend_h[2*a] = d[11:0]; pend_h[2*a+1] = d[27:16];
                end else begin
                    pend_v[2*(a-3)] = d[11:0]; pend_v[2*(a-3)+1] = d[27:16];
                end
            end
        end
        rn  = m_run();
        hin = mh < live_h[1];
        vin = mv < live_v[1];
        hr  = (mh >= live_h[2]) && (mh < live_h[5]);
        vr  = (mv >= live_v[2]) && (mv < live_v[5]);
        hd  = (mh >= live_h[3]) && (mh < live_h[4]);
        vd  = (mv >= live_v[3]) && (mv < live_v[4]);
        e.cyc  = cyc + 1;
        e.hs   = (rn && hin) ? mctl[1] : !mctl[1];
        e.vs   = (rn && vin) ? mctl[3] : !mctl[3];
        e.act  = rn && hd && vd;
        e.bord = rn && hr && vr && !(hd && vd);
        e.x    = rn ? mh : 12'd0;
        e.y    = rn ? mv : 12'd0;
        e.ph   = phase;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0);
    endtask

    // monitor: compare each queued item in the cycle it is due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R2", e.ph, {20'd0, h_pos, v_pos} >> 0, {8'd0, e.x, e.y});
            chk("R3", e.ph, {30'd0, hsync, vsync}, {30'd0, e.hs, e.vs});
            chk("R5", e.ph, {31'd0, active}, {31'd0, e.act});
            chk("R6", e.ph, {31'd0, border}, {31'd0, e.bord});
        end
    end

    always @(posedge clk) begin
        if (cyc == 100000) begin
            failures++;
            $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 100000)", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        mh = '0; mv = '0; mctl = '0; mrel = 1'b1;
        for (int i = 0; i < 6; i++) begin
            pend_h[i] = '0; pend_v[i] = '0; live_h[i] = '0; live_v[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: stopped, negative polarity, idle syncs high, origin
        chk("R10", "R10", {28'd0, hsync, vsync, active, border}, 32'hC);
        chk("R10", "R10", {8'd0, h_pos, v_pos}, 32'd0);

        // R1: timing words with junk in the ignored nibbles
        phase = "R1";
        step(1'b1, 3'd0, 32'hF002F014);   // sync end 2, period 20
        step(1'b1, 3'd1, 32'hA006A004);   // visible 6, lead border 4
        step(1'b1, 3'd2, 32'h5010500E);   // porch 16, trail border 14
        step(1'b1, 3'd3, 32'hF001F00A);   // sync end 1, period 10
        step(1'b1, 3'd4, 32'h3003C002);   // visible 3, lead border 2
        step(1'b1, 3'd5, 32'h90086007);   // porch 8, trail border 7
        step(1'b1, 3'd6, 32'h80000002);   // run, +hsync, -vsync
        idle(420);

        // R4: polarity swap while running
        phase = "R4";
        step(1'b1, 3'd6, 32'h80000008);
        idle(210);

        // R8: mid-frame timing change waits for the frame wrap
        phase = "R8";
        idle(37);
        step(1'b1, 3'd0, 32'h00020018);   // period 24
        step(1'b1, 3'd2, 32'h00120010);   // porch 18, trail border 16
        idle(500);

        // R7: either stop bit halts the raster, restart from origin
        phase = "R7";
        step(1'b1, 3'd6, 32'h8000000C);
        idle(30);
        step(1'b1, 3'd6, 32'h80000003);
        idle(10);
        step(1'b1, 3'd6, 32'h8000000A);
        idle(60);

        // R9: soft reset clears control and ignores other writes
        phase = "R9";
        step(1'b1, 3'd7, 32'h00000000);
        step(1'b1, 3'd6, 32'h8000000A);
        step(1'b1, 3'd0, 32'h0002001E);   // must be ignored
        idle(20);
        step(1'b1, 3'd7, 32'h00000100);
        idle(10);
        step(1'b1, 3'd6, 32'h8000000A);
        idle(260);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule